// File: doc/BRIEF.md
# Configurable Step Counter with Limit

The block is a synchronous counter whose register width, step, start value and mode are fixed by parameters. On each enabled clock it adds a nonzero step to its stored word and drives the stored word on its count output. The word is raw two's complement, so it may be read as signed or unsigned, and any fixed-point scaling stays outside the block. In free-running mode the word wraps modulo 2^WIDTH. In limit mode the counter returns to its start value once the stored word exactly equals a limit value.

Four optional controls can be switched on by parameter: a local synchronous reset, a load strobe with its load word, a count enable, and a direction input. The direction input negates the step instead of naming an absolute up or down. Any control switched off behaves as if held inactive.

The controls are resolved in a fixed priority order: local reset, then load, then enable, then direction. A global active-low reset also returns the counter to its start value.

Top module: `stepcnt_top`

## Requirements
- R1: While the asynchronous active-low reset `rstN` is low, `countOut` equals INIT_VAL.
- R2: When the local reset is high at a rising edge, `countOut` becomes INIT_VAL on that edge, whatever load, enable and direction are.
- R3: When the local reset is low and load is high at a rising edge, `countOut` becomes `loadVal`, whatever enable and direction are.
- R4: When the local reset, load and enable are all low at a rising edge, `countOut` keeps its value.
- R5: On an enabled edge with direction high (and no limit match), `countOut` becomes the old value plus STEP_VAL modulo 2^WIDTH.
- R6: On an enabled edge with direction low (and no limit match), `countOut` becomes the old value minus STEP_VAL modulo 2^WIDTH, so the sign of the step is reversed.
- R7: In limit mode, an enabled edge that finds `countOut` equal to LIMIT_VAL sets it to INIT_VAL, whatever direction is. This includes a LIMIT_VAL that was just loaded. LIMIT_VAL is therefore visible on the output for exactly one enabled cycle.
- R8: The limit test is exact equality. A step that wraps past LIMIT_VAL without landing on it does not restart the count.
- R9: A control whose HAS_* parameter is 0 is ignored and acts as inactive. For example, with HAS_DIR=0 the step is always added, even while the direction pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset to INIT_VAL |
| localRst | input | 1 | Synchronous reset to INIT_VAL, highest priority |
| loadEn | input | 1 | Load `loadVal` into the counter |
| loadVal | input | WIDTH | Word to load, same format as the count |
| countEn | input | 1 | Count enable; low holds the value |
| dirUp | input | 1 | High adds the step, low subtracts it |
| countOut | output | WIDTH | Registered counter value |

## Verification
A wrong stored word shows at `countOut` on the very next edge, because the output is the register itself. Every later value in the sequence then carries the same offset. A misplaced limit comparison behaves differently. It shows only when the sequence reaches LIMIT_VAL: one extra step past it, or an early return to INIT_VAL. For that reason the bench walks a limit-mode instance through a full period, including a wrap past the limit and a loaded limit value. A priority mistake between reset, load and enable shows up on the single edge where two controls are high together, and the bench drives those combinations directly.

// File: rtl/stepcnt_pkg.sv
package stepcnt_pkg;

  typedef enum logic {
    MODE_FREE  = 1'b0,
    MODE_LIMIT = 1'b1
  } cntMode_e;

  // strobes from the control decoder to the datapath register
  typedef struct packed {
    logic doInit;   // reload start value (local reset)
    logic doLoad;   // take external load word
    logic doStep;   // apply step
    logic doWrap;   // limit reached: reload start value
    logic negate;   // subtract instead of add
  } cntStrobe_t;

endpackage

// File: rtl/stepcnt_ctrl.sv
module stepcnt_ctrl
  import stepcnt_pkg::*;
#(
  parameter int                 WIDTH     = 8,
  parameter cntMode_e           MODE      = MODE_FREE,
  parameter logic [WIDTH-1:0]   INIT_VAL  = '0,
  parameter logic [WIDTH-1:0]   LIMIT_VAL = WIDTH'(100)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rstReq,
  input  logic             loadReq,
  input  logic             enReq,
  input  logic             upReq,
  input  logic [WIDTH-1:0] curCount,
  output cntStrobe_t       strobe
);

  localparam bit LimitMode = (MODE == MODE_LIMIT);

  logic limitHit;

  generate
    if (LimitMode) begin : g_limit
      assign limitHit = (curCount == LIMIT_VAL);
    end else begin : g_free
      assign limitHit = 1'b0;
    end
  endgenerate

  always_comb begin
    strobe = '0;
    if (rstReq) begin
      strobe.doInit = 1'b1;
    end else if (loadReq) begin
      strobe.doLoad = 1'b1;
    end else if (enReq) begin
      if (limitHit) begin
        strobe.doWrap = 1'b1;
      end else begin
        strobe.doStep = 1'b1;
        strobe.negate = !upReq;
      end
    end
  end

  // R7
  limit_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWrap |=> (curCount == INIT_VAL));

  // R2
  local_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> (curCount == INIT_VAL));

endmodule

// File: rtl/stepcnt_dp.sv
module stepcnt_dp
  import stepcnt_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] INIT_VAL = '0,
  parameter logic [WIDTH-1:0] STEP_VAL = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] cnt
);

  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] nextCnt;

  // add/subtract in raw two's complement: identical for signed and unsigned
  assign stepped = strobe.negate ? (cnt - STEP_VAL) : (cnt + STEP_VAL);

  always_comb begin
    nextCnt = cnt;
    if (strobe.doInit || strobe.doWrap) begin
      nextCnt = INIT_VAL;
    end else if (strobe.doLoad) begin
      nextCnt = loadVal;
    end else if (strobe.doStep) begin
      nextCnt = stepped;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= INIT_VAL;
    end else begin
      cnt <= nextCnt;
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(cnt));

  // R5
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doStep && !strobe.negate) |=> (cnt == $past(cnt) + STEP_VAL));

  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doStep && strobe.negate) |=> (cnt == $past(cnt) - STEP_VAL));

endmodule

// File: rtl/stepcnt_top.sv
module stepcnt_top
  import stepcnt_pkg::*;
#(
  parameter int               WIDTH         = 8,
  parameter bit               IS_SIGNED     = 1'b0,
  parameter cntMode_e         MODE          = MODE_FREE,
  parameter logic [WIDTH-1:0] INIT_VAL      = '0,
  parameter logic [WIDTH-1:0] STEP_VAL      = WIDTH'(1),
  parameter logic [WIDTH-1:0] LIMIT_VAL     = WIDTH'(100),
  parameter bit               HAS_LOCAL_RST = 1'b1,
  parameter bit               HAS_LOAD      = 1'b1,
  parameter bit               HAS_ENABLE    = 1'b1,
  parameter bit               HAS_DIR       = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             localRst,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             countEn,
  input  logic             dirUp,
  output logic [WIDTH-1:0] countOut
);

  localparam int MinWidth = IS_SIGNED ? 2 : 1;

  logic       rstEff;
  logic       loadEff;
  logic       enEff;
  logic       upEff;
  cntStrobe_t strobe;

  // optional controls: switched-off ones are tied to their inactive level
  generate
    if (HAS_LOCAL_RST) begin : g_rst
      assign rstEff = localRst;
    end else begin : g_no_rst
      logic unusedRst;
      assign unusedRst = localRst;
      assign rstEff    = 1'b0;
    end
    if (HAS_LOAD) begin : g_load
      assign loadEff = loadEn;
    end else begin : g_no_load
      logic unusedLoad;
      assign unusedLoad = loadEn;
      assign loadEff    = 1'b0;
    end
    if (HAS_ENABLE) begin : g_en
      assign enEff = countEn;
    end else begin : g_no_en
      logic unusedEn;
      assign unusedEn = countEn;
      assign enEff    = 1'b1;
    end
    if (HAS_DIR) begin : g_dir
      assign upEff = dirUp;
    end else begin : g_no_dir
      logic unusedDir;
      assign unusedDir = dirUp;
      assign upEff     = 1'b1;
    end
  endgenerate

  stepcnt_ctrl #(
    .WIDTH    (WIDTH),
    .MODE     (MODE),
    .INIT_VAL (INIT_VAL),
    .LIMIT_VAL(LIMIT_VAL)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rstReq  (rstEff),
    .loadReq (loadEff),
    .enReq   (enEff),
    .upReq   (upEff),
    .curCount(countOut),
    .strobe  (strobe)
  );

  stepcnt_dp #(
    .WIDTH   (WIDTH),
    .INIT_VAL(INIT_VAL),
    .STEP_VAL(STEP_VAL)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .loadVal(loadVal),
    .cnt    (countOut)
  );

  initial begin
    if (WIDTH < MinWidth) $display("stepcnt_top: WIDTH below minimum %0d", MinWidth);
  end

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rstEff && loadEff) |=> (countOut == $past(loadVal)));

  // R1
  reset_value_chk: assert property (@(posedge clk)
    !rstN |-> (countOut == INIT_VAL));

endmodule

// File: tb/stepcnt_top_bench.sv
`timescale 1ns/1ps
module stepcnt_top_bench;
  import stepcnt_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       localRst = 1'b0;
  logic       loadEn = 1'b0;
  logic       countEn = 1'b0;
  logic       dirUp = 1'b1;
  logic [2:0] loadValA = '0;
  logic [3:0] loadValF = '0;
  logic [2:0] cntA;
  logic [3:0] cntF;

  int nChecks = 0;
  int nErrs = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [2:0] a;
    logic [3:0] f;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [2:0] modA = 3'd0;
  logic [3:0] modF = 4'd0;

  always #4 clk = ~clk;

  // limit mode: 3-bit unsigned, start 0, step 3, limit 7, all controls
  stepcnt_top #(
    .WIDTH(3), .IS_SIGNED(1'b0), .MODE(MODE_LIMIT),
    .INIT_VAL(3'd0), .STEP_VAL(3'd3), .LIMIT_VAL(3'd7)
  ) u_stepcnt_top (
    .clk(clk), .rstN(rstN), .localRst(localRst), .loadEn(loadEn),
    .loadVal(loadValA), .countEn(countEn), .dirUp(dirUp), .countOut(cntA)
  );

  // free mode: 4-bit signed, start 0, step -2, direction control switched off
  stepcnt_top #(
    .WIDTH(4), .IS_SIGNED(1'b1), .MODE(MODE_FREE),
    .INIT_VAL(4'd0), .STEP_VAL(4'hE), .LIMIT_VAL(4'd0), .HAS_DIR(1'b0)
  ) u_stepcnt_topFree (
    .clk(clk), .rstN(rstN), .localRst(localRst), .loadEn(loadEn),
    .loadVal(loadValF), .countEn(countEn), .dirUp(dirUp), .countOut(cntF)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  endtask

  // driver: applies one cycle of controls and pushes the expected result
  task automatic drive(input logic r, input logic l, input logic e, input logic d,
                       input logic [2:0] va, input logic [3:0] vf, input string tag);
    expItem_t it;
    @(negedge clk);
    localRst = r; loadEn = l; countEn = e; dirUp = d;
    loadValA = va; loadValF = vf;
    if (r) modA = 3'd0;
    else if (l) modA = va;
    else if (e) begin
      if (modA == 3'd7) modA = 3'd0;
      else modA = d ? modA + 3'd3 : modA - 3'd3;
    end
    if (r) modF = 4'd0;
    else if (l) modF = vf;
    else if (e) modF = modF + 4'hE;
    it.a = modA; it.f = modF; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compares after each edge once the registers have settled
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check({it.tag, " limit-mode count"}, int'(cntA), int'(it.a));
      check({it.tag, " free-mode count"}, int'(cntF), int'(it.f));
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nErrs++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1 reset A", int'(cntA), 0);
    check("R1 reset F", int'(cntF), 0);
    rstN = 1'b1;

    // R5 up steps with wrap; 6->1 passes over 7 (R8); 7 -> 0 (R7)
    drive(0, 0, 1, 1, 3'd0, 4'd0, "R5");   // A 3   F 14
    drive(0, 0, 1, 1, 3'd0, 4'd0, "R5");   // A 6   F 12
    drive(0, 0, 1, 1, 3'd0, 4'd0, "R8");   // A 1   F 10
    drive(0, 0, 1, 1, 3'd0, 4'd0, "R5");   // A 4   F 8
    drive(0, 0, 1, 1, 3'd0, 4'd0, "R5");   // A 7   F 6
    drive(0, 0, 1, 1, 3'd0, 4'd0, "R7");   // A 0   F 4

    // R6 down steps; free instance ignores direction (R9)
    drive(0, 0, 1, 0, 3'd0, 4'd0, "R6");   // A 5   F 2
    drive(0, 0, 1, 0, 3'd0, 4'd0, "R9");   // A 2   F 0
    drive(0, 0, 1, 0, 3'd0, 4'd0, "R6");   // A 7   F 14
    drive(0, 0, 1, 0, 3'd0, 4'd0, "R7");   // A 0 regardless of dir  F 12

    // R4 hold
    drive(0, 0, 0, 1, 3'd5, 4'd9, "R4");
    drive(0, 0, 0, 0, 3'd5, 4'd9, "R4");

    // R3 load beats enable; loaded limit wraps next enabled edge (R7)
    drive(0, 1, 1, 1, 3'd7, 4'd5, "R3");   // A 7   F 5
    drive(0, 0, 1, 1, 3'd0, 4'd0, "R7");   // A 0   F 3
    drive(0, 1, 0, 0, 3'd2, 4'd9, "R3");   // A 2   F 9 (enable low)
    drive(0, 0, 1, 1, 3'd0, 4'd0, "R5");   // A 5   F 7

    // R2 local reset beats load and enable
    drive(1, 1, 1, 1, 3'd6, 4'd6, "R2");   // A 0   F 0
    drive(0, 0, 1, 0, 3'd0, 4'd0, "R6");   // A 5   F 14
    drive(0, 0, 0, 0, 3'd0, 4'd0, "R4");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule